// File: doc/BRIEF.md
# Reloading Modulus Counter

This block is a 16-bit up-counter that, instead of wrapping to zero, reloads itself from a software-written modulus value each time it steps past its all-ones state. Each reload raises a sticky overflow flag. While the flag is set and a non-zero priority level is programmed, the block raises an interrupt request at that level. The count can be placed on either or both of two shared time-base buses. A registered control word sets the step source, the bus drive, the interrupt level, one arbitration bit and the pin-edge reload.

Software reaches the block through a small register port with three live addresses: the control word, the count and the modulus. The counter advances by one on whichever of eight incoming tick enables the step-source field selects. A synchronized external load pin can also copy the modulus into the count on a chosen edge. The overflow flag can only be cleared by a read-then-write exchange, and that exchange is cancelled if a new overflow lands between the read and the write.

Top module: `modcnt_unit`

## Requirements
- R1: When a selected tick arrives while the count is 0xFFFF, the next count is the modulus value held at that moment, not zero.
- R2: The overflow flag (control bit 15) becomes 1 only on an R1 reload. Writing 1 to bit 15, loading from the pin, and writing the count never set it.
- R3: The flag clears when a control write with bit 15 = 0 follows a control read that saw the flag at 1. A write with no such read, or a write that comes after an overflow occurring after that read, leaves the flag set. Any control write ends the armed state.
- R4: `irq_req` is 1 and `irq_level` equals the level field (control bits 14:12) exactly while the flag is 1 and the level is non-zero. Otherwise `irq_req` is 0 and `irq_level` is 0.
- R5: The control word is laid out as: bit 15 flag, 14:12 level, 11 arbitration bit (also on `arb_bit3`), 9 drive bus A, 8 drive bus B, 7 synchronized `aux_pin` level (read-only), 6 synchronized `load_pin` level (read-only), 5 falling-edge load enable, 4 rising-edge load enable, 2:0 step-source select. Writing 0xFFFF with both pins low reads back 0x7B37.
- R6: The drive pair {bit 9, bit 8} decodes as 00 no bus, 01 bus B only, 10 bus A only, 11 both, on `tbus_a_en`/`tbus_b_en`. `tbus_data` always carries the count.
- R7: After reset the control word, count and modulus all read 0 and `irq_req` is 0. Bits 10 and 3 always read 0. Address 3 reads 0, and writes to it change nothing.
- R8: The step-source select s makes the count advance by exactly one on each cycle in which `tick_en[s]` is 1. The other tick bits have no effect.
- R9: Address 1 reads and writes the count; a write loads it directly. Address 2 reads and writes the modulus, and writing it leaves the running count untouched.
- R10: With bit 4 set, a rising edge on `load_pin` copies the modulus into the count. With bit 5 set, a falling edge does the same. Each load takes effect within three cycles of the pin change, after a two-flop synchronizer, and never sets the flag. An edge whose enable is clear does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 control, 1 count, 2 modulus, 3 reserved |
| bus_rd | input | 1 | Read strobe (arms the flag clear) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| tick_en | input | 8 | Prescaler tick enables |
| load_pin | input | 1 | External load pin (asynchronous) |
| aux_pin | input | 1 | Auxiliary pin, level readable only |
| tbus_a_en | output | 1 | Count is driven onto time-base bus A |
| tbus_b_en | output | 1 | Count is driven onto time-base bus B |
| tbus_data | output | 16 | Current count |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Requested level, 0 when idle |
| arb_bit3 | output | 1 | Stored arbitration bit |

## Verification
The assertions assume that a read strobe and a write strobe are never active in the same cycle. They also assume that `bus_wdata` is meaningful only while `bus_wr` is high, so a clear is attributed to the write seen in the cycle before the flag falls. The bench raises each strobe for exactly one cycle and changes the pins only on the falling clock edge. The step-source sweep pulses one tick bit at a time, so every step can be credited to a single select value. It holds ticks at zero while testing pin loads, so those loads can be told apart from stepping.

// File: rtl/modcnt_pkg.sv
package modcnt_pkg;
    localparam int REG_W   = 16;
    localparam int NTICK   = 8;
    localparam int SEL_W   = $clog2(NTICK);
    localparam int LVL_W   = 3;

    typedef enum logic [1:0] {
        ADR_CTRL  = 2'd0,
        ADR_COUNT = 2'd1,
        ADR_MOD   = 2'd2,
        ADR_RSVD  = 2'd3
    } adr_e;

    typedef struct packed {
        logic             flag;
        logic [LVL_W-1:0] lvl;
        logic             arb3;
        logic             drv_a;
        logic             drv_b;
        logic             edge_neg;
        logic             edge_pos;
        logic [SEL_W-1:0] csel;
    } ctrl_t;

    function automatic logic [REG_W-1:0] pack_ctrl(ctrl_t c, logic aux_lvl, logic ld_lvl);
        return {c.flag, c.lvl, c.arb3, 1'b0, c.drv_a, c.drv_b,
                aux_lvl, ld_lvl, c.edge_neg, c.edge_pos, 1'b0, c.csel};
    endfunction

    function automatic ctrl_t unpack_wr(logic [REG_W-1:0] w);
        ctrl_t c;
        c.flag     = w[15];
        c.lvl      = w[14:12];
        c.arb3     = w[11];
        c.drv_a    = w[9];
        c.drv_b    = w[8];
        c.edge_neg = w[5];
        c.edge_pos = w[4];
        c.csel     = w[2:0];
        return c;
    endfunction
endpackage

// File: rtl/modcnt_edge.sv
module modcnt_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load_pin,
    input  logic aux_pin,
    output logic ld_lvl,
    output logic aux_lvl,
    output logic ld_rise,
    output logic ld_fall
);
    logic [STAGES:0]   ld_sr;
    logic [STAGES-1:0] aux_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_sr  <= '0;
            aux_sr <= '0;
        end else begin
            ld_sr  <= {ld_sr[STAGES-1:0], load_pin};
            aux_sr <= {aux_sr[STAGES-2:0], aux_pin};
        end
    end

    assign ld_lvl  = ld_sr[STAGES-1];
    assign aux_lvl = aux_sr[STAGES-1];
    assign ld_rise = ld_sr[STAGES-1] & ~ld_sr[STAGES];
    assign ld_fall = ~ld_sr[STAGES-1] & ld_sr[STAGES];
endmodule

// File: rtl/modcnt_core.sv
module modcnt_core
    import modcnt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NTICK-1:0] tick_en,
    input  logic [SEL_W-1:0] csel,
    input  logic             wr_cnt,
    input  logic             wr_mod,
    input  logic [CNT_W-1:0] wval,
    input  logic             load_evt,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] mod_q,
    output logic             ovf_evt
);
    logic step;

    assign step    = tick_en[csel];
    assign ovf_evt = step && (cnt_q == '1) && !wr_cnt && !load_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wval;
        end else if (load_evt) begin
            cnt_q <= mod_q;
        end else if (ovf_evt) begin
            cnt_q <= mod_q;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mod_q <= '0;
        end else if (wr_mod) begin
            mod_q <= wval;
        end
    end
endmodule

// File: rtl/modcnt_ctrl.sv
module modcnt_ctrl
    import modcnt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_ctrl,
    input  logic  rd_ctrl,
    input  ctrl_t wval,
    input  logic  ovf_evt,
    output ctrl_t ctrl_q
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            armed  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.lvl      <= wval.lvl;
                ctrl_q.arb3     <= wval.arb3;
                ctrl_q.drv_a    <= wval.drv_a;
                ctrl_q.drv_b    <= wval.drv_b;
                ctrl_q.edge_neg <= wval.edge_neg;
                ctrl_q.edge_pos <= wval.edge_pos;
                ctrl_q.csel     <= wval.csel;
            end
            if (ovf_evt) begin
                ctrl_q.flag <= 1'b1;
            end else if (wr_ctrl && !wval.flag && armed) begin
                ctrl_q.flag <= 1'b0;
            end
            if (ovf_evt || wr_ctrl) begin
                armed <= 1'b0;
            end else if (rd_ctrl && ctrl_q.flag) begin
                armed <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/modcnt_unit.sv
module modcnt_unit
    import modcnt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic [NTICK-1:0] tick_en,
    input  logic             load_pin,
    input  logic             aux_pin,
    output logic             tbus_a_en,
    output logic             tbus_b_en,
    output logic [CNT_W-1:0] tbus_data,
    output logic             irq_req,
    output logic [LVL_W-1:0] irq_level,
    output logic             arb_bit3
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mod_q;
    logic             ovf_evt;
    logic             ld_lvl, aux_lvl, ld_rise, ld_fall;
    logic             load_evt;
    logic             wr_ctrl, wr_cnt, wr_mod, rd_ctrl;
    logic             unused_wbits;

    assign wr_ctrl = bus_wr && (adr_e'(bus_addr) == ADR_CTRL);
    assign wr_cnt  = bus_wr && (adr_e'(bus_addr) == ADR_COUNT);
    assign wr_mod  = bus_wr && (adr_e'(bus_addr) == ADR_MOD);
    assign rd_ctrl = bus_rd && (adr_e'(bus_addr) == ADR_CTRL);
    assign unused_wbits = ^{bus_wdata[10], bus_wdata[7:6], bus_wdata[3]};

    modcnt_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .load_pin(load_pin), .aux_pin(aux_pin),
        .ld_lvl(ld_lvl), .aux_lvl(aux_lvl), .ld_rise(ld_rise), .ld_fall(ld_fall)
    );

    assign load_evt = (ctrl_q.edge_pos && ld_rise) || (ctrl_q.edge_neg && ld_fall);

    modcnt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .tick_en(tick_en), .csel(ctrl_q.csel),
        .wr_cnt(wr_cnt), .wr_mod(wr_mod), .wval(bus_wdata[CNT_W-1:0]),
        .load_evt(load_evt), .cnt_q(cnt_q), .mod_q(mod_q), .ovf_evt(ovf_evt)
    );

    modcnt_ctrl u_ctrl (
        .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .rd_ctrl(rd_ctrl),
        .wval(unpack_wr(bus_wdata)), .ovf_evt(ovf_evt), .ctrl_q(ctrl_q)
    );

    always_comb begin
        case (adr_e'(bus_addr))
            ADR_CTRL:  bus_rdata = pack_ctrl(ctrl_q, aux_lvl, ld_lvl);
            ADR_COUNT: bus_rdata = REG_W'(cnt_q);
            ADR_MOD:   bus_rdata = REG_W'(mod_q);
            default:   bus_rdata = '0;
        endcase
    end

    assign tbus_a_en = ctrl_q.drv_a;
    assign tbus_b_en = ctrl_q.drv_b;
    assign tbus_data = cnt_q;
    assign irq_req   = ctrl_q.flag && (ctrl_q.lvl != '0);
    assign irq_level = irq_req ? ctrl_q.lvl : '0;
    assign arb_bit3  = ctrl_q.arb3;
endmodule

// File: rtl/modcnt_unit_chk.sv
module modcnt_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ovf_evt,
    input logic             flag,
    input logic [CNT_W-1:0] mod_q,
    input logic [CNT_W-1:0] tbus_data,
    input logic             irq_req,
    input logic [2:0]       irq_level,
    input logic [1:0]       bus_addr,
    input logic             bus_wr,
    input logic [15:0]      bus_wdata,
    input logic [15:0]      bus_rdata
);
    // R1: a wrap puts the previous modulus on the count
    a_r1_wrap_reload: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> (tbus_data == $past(mod_q)));

    // R2: every wrap raises the flag
    a_r2_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> flag);

    // R2: the flag rises for no other reason
    a_r2_no_stray_set: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(ovf_evt));

    // R3: the flag falls only after a control write carrying a zero in bit 15
    a_r3_clear_by_write: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(bus_wr && bus_addr == 2'd0 && !bus_wdata[15]));

    // R4: the request implies a set flag and a non-zero level
    a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (flag && irq_level != 3'd0));

    // R4: no request while the flag is clear
    a_r4_irq_idle: assert property (@(posedge clk) disable iff (rst)
        !flag |-> (!irq_req && irq_level == 3'd0));

    // R7: reserved bits and the reserved address read as zero
    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd0) |-> (bus_rdata[10] == 1'b0 && bus_rdata[3] == 1'b0));

    a_r7_rsvd_addr_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd3) |-> (bus_rdata == 16'h0000));
endmodule

bind modcnt_unit modcnt_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .ovf_evt(ovf_evt), .flag(ctrl_q.flag),
    .mod_q(mod_q), .tbus_data(tbus_data), .irq_req(irq_req),
    .irq_level(irq_level), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
);

// File: tb/modcnt_unit_bench.sv
module modcnt_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [7:0]  tick_en = 8'h0;
    logic        load_pin = 1'b0;
    logic        aux_pin = 1'b0;
    logic        tbus_a_en, tbus_b_en;
    logic [15:0] tbus_data;
    logic        irq_req;
    logic [2:0]  irq_level;
    logic        arb_bit3;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    modcnt_unit u_modcnt_unit (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .load_pin(load_pin), .aux_pin(aux_pin),
        .tbus_a_en(tbus_a_en), .tbus_b_en(tbus_b_en), .tbus_data(tbus_data),
        .irq_req(irq_req), .irq_level(irq_level), .arb_bit3(arb_bit3)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick(input int b);
        @(negedge clk);
        tick_en = 8'(1 << b);
        @(negedge clk);
        tick_en = 8'h0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [15:0] v;
        logic [15:0] exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7 reset state
        rd(2'd0, v); check("R7 ctrl reset", v, 16'h0000);
        rd(2'd1, v); check("R7 count reset", v, 16'h0000);
        rd(2'd2, v); check("R7 modulus reset", v, 16'h0000);
        check("R7 irq reset", irq_req, 0);

        // R5 layout, writable bits
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v); check("R5 layout all ones", v, 16'h7B37);
        check("R5 arb bit out", arb_bit3, 1);
        check("R2 flag not writable", v[15], 0);

        // R6 drive decode sweep
        for (int d = 0; d < 4; d++) begin
            wr(2'd0, 16'(d << 8));
            idle(1);
            check("R6 drive decode", {tbus_a_en, tbus_b_en}, d);
        end

        // R8 step source sweep
        for (int s = 0; s < 8; s++) begin
            wr(2'd0, 16'(s));
            wr(2'd1, 16'h0100);
            exp = 16'h0100;
            for (int b = 0; b < 8; b++) begin
                tick(b);
                if (b == s) exp = exp + 16'd1;
                idle(1);
                check("R8 select step", tbus_data, exp);
            end
        end

        // R9 modulus write leaves count alone, count write loads
        wr(2'd1, 16'h0005);
        wr(2'd2, 16'h0777);
        rd(2'd1, v); check("R9 count kept", v, 16'h0005);
        rd(2'd2, v); check("R9 modulus readback", v, 16'h0777);
        wr(2'd0, 16'h0000);
        tick(0);
        rd(2'd1, v); check("R9 count steps", v, 16'h0006);

        // R1 / R2 wrap
        wr(2'd2, 16'hFFF0);
        wr(2'd1, 16'hFFFE);
        tick(0);
        rd(2'd0, v); check("R2 no flag before wrap", v[15], 0);
        check("R1 at max", tbus_data, 16'hFFFF);
        tick(0);
        check("R1 reload to modulus", tbus_data, 16'hFFF0);
        rd(2'd0, v); check("R2 flag set", v[15], 1);
        check("R4 level zero no irq", irq_req, 0);

        // R4 level set while flag kept by writing 1
        wr(2'd0, 16'hD000);
        idle(1);
        check("R4 irq raised", irq_req, 1);
        check("R4 irq level", irq_level, 3'd5);

        // R3 write without read does not clear
        wr(2'd0, 16'h5000);
        rd(2'd1, v);
        check("R3 no read no clear", irq_req, 1);

        // R3 overflow between read and write cancels
        rd(2'd0, v);
        wr(2'd1, 16'hFFFF);
        tick(0);
        wr(2'd0, 16'h5000);
        idle(1);
        check("R3 overflow cancels clear", irq_req, 1);

        // R3 proper handshake clears
        rd(2'd0, v);
        wr(2'd0, 16'h5000);
        rd(2'd0, v); check("R3 flag cleared", v[15], 0);
        check("R4 irq drops", irq_req, 0);

        // R10 edge loads
        wr(2'd0, 16'h0010);
        wr(2'd2, 16'hABC0);
        wr(2'd1, 16'h1234);
        @(negedge clk); load_pin = 1'b1;
        idle(4);
        check("R10 rising load", tbus_data, 16'hABC0);
        rd(2'd0, v);
        check("R10 no flag on load", v[15], 0);
        check("R5 load pin level", v[6], 1);
        wr(2'd1, 16'h1111);
        @(negedge clk); load_pin = 1'b0;
        idle(4);
        check("R10 falling ignored", tbus_data, 16'h1111);
        wr(2'd0, 16'h0020);
        @(negedge clk); load_pin = 1'b1;
        idle(4);
        check("R10 rising ignored", tbus_data, 16'h1111);
        @(negedge clk); load_pin = 1'b0;
        idle(4);
        check("R10 falling load", tbus_data, 16'hABC0);

        // R5 aux level
        @(negedge clk); aux_pin = 1'b1;
        idle(3);
        rd(2'd0, v); check("R5 aux pin level", v[7], 1);

        // R7 reserved address
        wr(2'd3, 16'hFFFF);
        rd(2'd3, v); check("R7 reserved reads zero", v, 16'h0000);
        rd(2'd0, v); check("R7 reserved write no effect", v, 16'h0020 | 16'h0080);
        rd(2'd2, v); check("R7 modulus untouched", v, 16'hABC0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule